// File: doc/BRIEF.md
# Counter Clock and Gate Source Router

This block chooses, for every counter channel in a timer subsystem, which signal acts as that channel's clock enable and which signal acts as its gate level. The channels are organised as three groups. Each group holds two banks of three channels, so the default build serves eighteen channels. Software reprograms one channel at a time through a byte write port. Each group has one clock-select register and one gate-select register. A written byte names a bank, a channel inside that bank and a source code.

The available sources are these. A decade prescaler produces single-cycle pulses at five rates. Each channel has a dedicated clock pin and a dedicated gate pin. Each group has one shared auxiliary input. There are also constant levels. A separate one-bit extension register widens the source code from three bits to five. The wider range unlocks a full-rate source. Every other code in the wider range is unassigned and drives the output low.

The outputs are combinational from the stored selections, the prescaler state and the input pins. A counter therefore sees a changed input pin in the same cycle. Pulse periods are given in clock cycles. With a 20 MHz system clock they correspond to 10 MHz, 1 MHz, 100 kHz, 10 kHz and 1 kHz.

Top module: `cnt_src_router`

## Requirements
- R1: After reset every channel has clock code 0 and gate code 0, and the extension bit is clear. So every gate output is 1, and every clock enable equals that channel's dedicated clock pin.
- R2: A write to address 0x18+g (g = 0..2) sets a clock code, and a write to 0x1B+g sets a gate code. The byte is decoded as follows: bit 5 is the bank, bits 4:3 are the channel, and the code is {bits 7:6, bits 2:0}. The write updates only channel g*6 + bank*3 + channel, and the new selection is visible in the cycle after the write edge.
- R3: A select write whose channel field is 3 changes no stored selection.
- R4: Codes 1 to 5 select single-cycle pulses with periods of 2, 20, 200, 2000 and 20000 cycles. The pulse of period D is high in the cycles where (n+1) is a multiple of D. Here n is the number of clock edges since the internal reset was released.
- R5: Code 6 selects the group's auxiliary input for both the clock and the gate. Gate code 7 selects the channel's dedicated gate pin. Clock code 7 drives low.
- R6: While the extension bit is clear, code bits 4:3 are ignored and only the low three bits of the stored code take effect.
- R7: A write to 0x20 loads data bit 0 into the extension bit. While the extension bit is set, the full 5-bit code is used, and code 11 holds the output high in every cycle.
- R8: With the extension bit set, codes 8 to 10 and 12 to 31 drive both the clock enable and the gate low.
- R9: Writes to any other address leave all selections and the extension bit unchanged.
- R10: A change on a dedicated pin or an auxiliary input reaches a channel that selects it in the same cycle.
- R11: The internal reset is asserted asynchronously and released on the second clock edge after rst_n rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 6 | Byte write address |
| wr_data | input | 8 | Byte write data |
| chan_clk_in | input | 18 | Dedicated clock pin per channel (clock-enable form) |
| chan_gate_in | input | 18 | Dedicated gate pin per channel |
| grp_aux_in | input | 3 | Shared auxiliary input per group |
| cnt_clk_en | output | 18 | Selected clock enable per channel |
| cnt_gate | output | 18 | Selected gate level per channel |

## Verification
The bench builds the router with its default parameters: three groups of two banks of three channels, a first divider of 2 and decade dividers of 10. At these values the slowest 20000-cycle pulse can be observed for two full periods within the run, and every group, bank and channel index can be addressed. The bench randomises the pin inputs on every cycle, so the combinational pin paths are exercised continuously. Writes step through the basic range, the extended range, the masking of the upper code bits, the rejected channel number and foreign addresses.

// File: rtl/ctr_route_pkg.sv
package ctr_route_pkg;

  localparam int SRC_W     = 5;
  localparam int NUM_TICKS = 5;

  typedef logic [SRC_W-1:0] src_code_t;

  localparam src_code_t SRC_DEDICATED = 5'd0;
  localparam src_code_t SRC_AUX       = 5'd6;
  localparam src_code_t SRC_ALT       = 5'd7;
  localparam src_code_t SRC_FULL_RATE = 5'd11;

  // Layout of a select byte; positions are decoded by the write logic.
  typedef struct packed {
    logic [1:0] src_hi;
    logic       bank;
    logic [1:0] chan;
    logic [2:0] src_lo;
  } sel_byte_t;

endpackage

// File: rtl/ctr_route_prescale.sv
module ctr_route_prescale
  import ctr_route_pkg::*;
#(
  parameter int FIRST_DIV  = 2,
  parameter int DECADE_DIV = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  output logic [NUM_TICKS-1:0] tick
);

  localparam int MAX_DIV = (FIRST_DIV > DECADE_DIV) ? FIRST_DIV : DECADE_DIV;
  localparam int CW      = (MAX_DIV > 2) ? $clog2(MAX_DIV) : 1;

  for (genvar s = 0; s < NUM_TICKS; s++) begin : g_stage
    localparam int DIV = (s == 0) ? FIRST_DIV : DECADE_DIV;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;
    logic          step;
    logic          tick_s;

    if (s == 0) begin : g_head
      assign step = 1'b1;
    end else begin : g_tail
      assign step = tick[s-1];
    end

    always_comb begin
      cnt_d  = cnt_q;
      tick_s = step && (cnt_q == CW'(DIV - 1));
      if (step) begin
        if (cnt_q == CW'(DIV - 1)) cnt_d = '0;
        else                       cnt_d = cnt_q + 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
    end

    assign tick[s] = tick_s;

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      tick[s] |=> !tick[s]); // R4
  end

endmodule

// File: rtl/ctr_route_selregs.sv
module ctr_route_selregs
  import ctr_route_pkg::*;
#(
  parameter int NUM_GROUPS  = 3,
  parameter int CH_PER_BANK = 3,
  parameter int ADDR_W      = 6,
  parameter int CLK_BASE    = 'h18,
  parameter int GATE_BASE   = 'h1B,
  parameter int ENH_ADDR    = 'h20
) (
  input  logic                                           clk,
  input  logic                                           rst_n,
  input  logic                                           wr_en,
  input  logic [ADDR_W-1:0]                              wr_addr,
  input  logic [7:0]                                     wr_data,
  output src_code_t [NUM_GROUPS*2*CH_PER_BANK-1:0]       clk_sel,
  output src_code_t [NUM_GROUPS*2*CH_PER_BANK-1:0]       gate_sel,
  output logic                                           enhance
);

  localparam int CPG = 2 * CH_PER_BANK;
  localparam int NCH = NUM_GROUPS * CPG;

  sel_byte_t             wb;
  src_code_t             wcode;
  logic [NUM_GROUPS-1:0] clk_hit;
  logic [NUM_GROUPS-1:0] gate_hit;
  logic                  enh_hit;
  logic [NCH-1:0]        clk_we;
  logic [NCH-1:0]        gate_we;

  src_code_t [NCH-1:0]   clk_sel_q,  clk_sel_d;
  src_code_t [NCH-1:0]   gate_sel_q, gate_sel_d;
  logic                  enh_q, enh_d;

  assign wb      = sel_byte_t'(wr_data);
  assign wcode   = {wb.src_hi, wb.src_lo};
  assign enh_hit = wr_en && (wr_addr == ADDR_W'(ENH_ADDR));

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    assign clk_hit[g]  = wr_en && (wr_addr == ADDR_W'(CLK_BASE + g));
    assign gate_hit[g] = wr_en && (wr_addr == ADDR_W'(GATE_BASE + g));
  end

  for (genvar i = 0; i < NCH; i++) begin : g_we
    localparam int GI = i / CPG;
    localparam int BI = (i % CPG) / CH_PER_BANK;
    localparam int CI = i % CH_PER_BANK;
    logic slot_match;
    assign slot_match = (wb.bank == 1'(BI)) && (wb.chan == 2'(CI));
    assign clk_we[i]  = clk_hit[GI]  && slot_match;
    assign gate_we[i] = gate_hit[GI] && slot_match;
  end

  always_comb begin
    clk_sel_d  = clk_sel_q;
    gate_sel_d = gate_sel_q;
    enh_d      = enh_q;
    for (int i = 0; i < NCH; i++) begin
      if (clk_we[i])  clk_sel_d[i]  = wcode;
      if (gate_we[i]) gate_sel_d[i] = wcode;
    end
    if (enh_hit) enh_d = wr_data[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sel_q  <= '0;
      gate_sel_q <= '0;
      enh_q      <= 1'b0;
    end else begin
      clk_sel_q  <= clk_sel_d;
      gate_sel_q <= gate_sel_d;
      enh_q      <= enh_d;
    end
  end

  assign clk_sel  = clk_sel_q;
  assign gate_sel = gate_sel_q;
  assign enhance  = enh_q;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(clk_sel_q) && $stable(gate_sel_q) && $stable(enh_q))); // R2

  AST_CHAN3_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[4:3] == 2'd3) |=> ($stable(clk_sel_q) && $stable(gate_sel_q))); // R3

  AST_ENH_ONLY_OWN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != ADDR_W'(ENH_ADDR)) |=> $stable(enh_q)); // R7

  AST_FOREIGN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(|clk_hit) && !(|gate_hit) && !enh_hit)
      |=> ($stable(clk_sel_q) && $stable(gate_sel_q) && $stable(enh_q))); // R9

endmodule

// File: rtl/ctr_route_srcmux.sv
module ctr_route_srcmux
  import ctr_route_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enhance,
  input  src_code_t            clk_code,
  input  src_code_t            gate_code,
  input  logic [NUM_TICKS-1:0] tick,
  input  logic                 ded_clk,
  input  logic                 ded_gate,
  input  logic                 aux,
  output logic                 clk_en,
  output logic                 gate
);

  src_code_t eff_clk;
  src_code_t eff_gate;

  function automatic logic pick_tick(src_code_t c, logic [NUM_TICKS-1:0] t);
    logic r;
    r = 1'b0;
    for (int k = 0; k < NUM_TICKS; k++) begin
      if (c == src_code_t'(k + 1)) r = t[k];
    end
    return r;
  endfunction

  always_comb begin
    eff_clk  = enhance ? clk_code  : {2'b00, clk_code[2:0]};
    eff_gate = enhance ? gate_code : {2'b00, gate_code[2:0]};
  end

  always_comb begin
    case (eff_clk)
      SRC_DEDICATED: clk_en = ded_clk;
      SRC_AUX:       clk_en = aux;
      SRC_FULL_RATE: clk_en = 1'b1;
      default:       clk_en = pick_tick(eff_clk, tick);
    endcase
  end

  always_comb begin
    case (eff_gate)
      SRC_DEDICATED: gate = 1'b1;
      SRC_AUX:       gate = aux;
      SRC_ALT:       gate = ded_gate;
      SRC_FULL_RATE: gate = 1'b1;
      default:       gate = pick_tick(eff_gate, tick);
    endcase
  end

  AST_GATE_DEFAULT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_code == 5'd0) |-> gate); // R1

  AST_BASIC_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (!enhance && clk_code[2:0] == 3'd0) |-> (clk_en == ded_clk)); // R6

  AST_FULL_RATE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (enhance && clk_code == 5'd11) |-> clk_en); // R7

  AST_UNASSIGNED_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (enhance && clk_code > 5'd11) |-> !clk_en); // R8

  AST_UNASSIGNED_GATE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (enhance && gate_code > 5'd11) |-> !gate); // R8

endmodule

// File: rtl/cnt_src_router.sv
module cnt_src_router
  import ctr_route_pkg::*;
#(
  parameter int NUM_GROUPS  = 3,
  parameter int CH_PER_BANK = 3,
  parameter int ADDR_W      = 6,
  parameter int CLK_BASE    = 'h18,
  parameter int GATE_BASE   = 'h1B,
  parameter int ENH_ADDR    = 'h20,
  parameter int FIRST_DIV   = 2,
  parameter int DECADE_DIV  = 10
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_en,
  input  logic [ADDR_W-1:0]                    wr_addr,
  input  logic [7:0]                           wr_data,
  input  logic [NUM_GROUPS*2*CH_PER_BANK-1:0]  chan_clk_in,
  input  logic [NUM_GROUPS*2*CH_PER_BANK-1:0]  chan_gate_in,
  input  logic [NUM_GROUPS-1:0]                grp_aux_in,
  output logic [NUM_GROUPS*2*CH_PER_BANK-1:0]  cnt_clk_en,
  output logic [NUM_GROUPS*2*CH_PER_BANK-1:0]  cnt_gate
);

  localparam int CPG = 2 * CH_PER_BANK;
  localparam int NCH = NUM_GROUPS * CPG;

  logic [1:0]           rst_sync_q;
  logic                 rst_n_i;
  logic [NUM_TICKS-1:0] tick;
  src_code_t [NCH-1:0]  clk_sel;
  src_code_t [NCH-1:0]  gate_sel;
  logic                 enhance;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  assign rst_n_i = rst_sync_q[1];

  AST_RESET_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n_i) |-> $past(rst_sync_q[0])); // R11

  ctr_route_prescale #(
    .FIRST_DIV  (FIRST_DIV),
    .DECADE_DIV (DECADE_DIV)
  ) u_prescale (
    .clk   (clk),
    .rst_n (rst_n_i),
    .tick  (tick)
  );

  ctr_route_selregs #(
    .NUM_GROUPS  (NUM_GROUPS),
    .CH_PER_BANK (CH_PER_BANK),
    .ADDR_W      (ADDR_W),
    .CLK_BASE    (CLK_BASE),
    .GATE_BASE   (GATE_BASE),
    .ENH_ADDR    (ENH_ADDR)
  ) u_selregs (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .clk_sel  (clk_sel),
    .gate_sel (gate_sel),
    .enhance  (enhance)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    ctr_route_srcmux u_mux (
      .clk       (clk),
      .rst_n     (rst_n_i),
      .enhance   (enhance),
      .clk_code  (clk_sel[ch]),
      .gate_code (gate_sel[ch]),
      .tick      (tick),
      .ded_clk   (chan_clk_in[ch]),
      .ded_gate  (chan_gate_in[ch]),
      .aux       (grp_aux_in[ch / CPG]),
      .clk_en    (cnt_clk_en[ch]),
      .gate      (cnt_gate[ch])
    );
  end

endmodule

// File: tb/cnt_src_router_test.sv
module cnt_src_router_test;

  localparam int NCH   = 18;
  localparam int NGRP  = 3;
  localparam int LIMIT = 150000;

  logic            clk;
  logic            rst_n;
  logic            wr_en;
  logic [5:0]      wr_addr;
  logic [7:0]      wr_data;
  logic [NCH-1:0]  chan_clk_in;
  logic [NCH-1:0]  chan_gate_in;
  logic [NGRP-1:0] grp_aux_in;
  logic [NCH-1:0]  cnt_clk_en;
  logic [NCH-1:0]  cnt_gate;

  cnt_src_router uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .chan_clk_in  (chan_clk_in),
    .chan_gate_in (chan_gate_in),
    .grp_aux_in   (grp_aux_in),
    .cnt_clk_en   (cnt_clk_en),
    .cnt_gate     (cnt_gate)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int    checks = 0;
  int    fails  = 0;
  int    cyc    = 0;
  string cur_req = "R1";

  // reference model state
  int m_clk[NCH];
  int m_gate[NCH];
  int m_enh;
  int m_sync;
  int m_n;

  function automatic logic [7:0] mk(int bank, int ch, int src);
    logic [4:0] s;
    s = src[4:0];
    return {s[4:3], bank[0], ch[1:0], s[2:0]};
  endfunction

  function automatic bit tk(int d);
    return ((m_n + 1) % d) == 0;
  endfunction

  function automatic bit exp_val(int ch, int code, bit is_gate);
    int e;
    e = (m_enh != 0) ? code : (code & 7);
    case (e)
      0:  return is_gate ? 1'b1 : chan_clk_in[ch];
      1:  return tk(2);
      2:  return tk(20);
      3:  return tk(200);
      4:  return tk(2000);
      5:  return tk(20000);
      6:  return grp_aux_in[ch / 6];
      7:  return is_gate ? chan_gate_in[ch] : 1'b0;
      11: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        m_clk[i]  = 0;
        m_gate[i] = 0;
      end
      m_enh  = 0;
      m_sync = 0;
      m_n    = 0;
    end else if (m_sync < 2) begin
      m_sync = m_sync + 1;
    end else begin
      m_n = m_n + 1;
      if (wr_en) begin
        int a;
        int ch;
        int idx;
        a  = int'(wr_addr);
        ch = int'(wr_data[4:3]);
        idx = 0;
        if (ch < 3) idx = ((a >= 'h1B) ? (a - 'h1B) : (a - 'h18)) * 6
                          + int'(wr_data[5]) * 3 + ch;
        if (a >= 'h18 && a <= 'h1A && ch < 3)
          m_clk[idx] = int'({wr_data[7:6], wr_data[2:0]});
        if (a >= 'h1B && a <= 'h1D && ch < 3)
          m_gate[idx] = int'({wr_data[7:6], wr_data[2:0]});
        if (a == 'h20) m_enh = int'(wr_data[0]);
      end
    end
  end

  // input randomisation, away from the active edge
  always @(negedge clk) begin
    chan_clk_in  <= NCH'($urandom);
    chan_gate_in <= NCH'($urandom);
    grp_aux_in   <= NGRP'($urandom);
  end

  // cycle-by-cycle comparison with the model
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      logic [NCH-1:0] ec;
      logic [NCH-1:0] eg;
      for (int i = 0; i < NCH; i++) begin
        ec[i] = exp_val(i, m_clk[i], 1'b0);
        eg[i] = exp_val(i, m_gate[i], 1'b1);
      end
      checks++;
      if (ec !== cnt_clk_en || eg !== cnt_gate) begin
        fails++;
        if (fails < 20)
          $display("FAIL %s cycle %0d: clk_en=%h exp %h gate=%h exp %h",
                   cur_req, m_n, cnt_clk_en, ec, cnt_gate, eg);
      end
    end
  end

  task automatic check1(bit cond, string req, logic [NCH-1:0] act, logic [NCH-1:0] exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = a[5:0];
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > LIMIT) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, LIMIT);
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    wr_addr = '0;
    wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #3;
    // R1: reset selections
    check1(cnt_gate === '1, "R1 gate", cnt_gate, '1);
    check1(cnt_clk_en === chan_clk_in, "R1 clk", cnt_clk_en, chan_clk_in);

    // R11 reset release timing and R4 prescaled pulses
    cur_req = "R4";
    wr('h18, mk(0, 0, 1));
    wr('h18, mk(0, 1, 2));
    wr('h18, mk(0, 2, 3));
    wr('h18, mk(1, 0, 4));
    wr('h18, mk(1, 1, 5));
    wr('h1C, mk(0, 0, 1));
    wr('h1C, mk(1, 2, 5));
    wr('h1D, mk(0, 1, 4));
    repeat (42000) @(negedge clk);

    // R2: every group, bank and channel index
    cur_req = "R2";
    for (int g = 0; g < 3; g++)
      for (int b = 0; b < 2; b++)
        for (int c = 0; c < 3; c++) begin
          wr('h18 + g, mk(b, c, (g + b + c) % 8));
          wr('h1B + g, mk(b, c, (g + 2 * b + c + 3) % 8));
        end
    repeat (50) @(negedge clk);

    // R3: channel field 3
    cur_req = "R3";
    for (int g = 0; g < 3; g++) begin
      wr('h18 + g, mk(1, 3, 5));
      wr('h1B + g, mk(0, 3, 6));
      wr('h18 + g, mk(0, 3, 0));
    end
    repeat (30) @(negedge clk);

    // R5 and R10: auxiliary and dedicated pins
    cur_req = "R5";
    wr('h18, mk(0, 0, 6));
    wr('h1B, mk(0, 0, 7));
    wr('h19, mk(1, 2, 7));
    wr('h1A, mk(1, 1, 6));
    wr('h1D, mk(1, 1, 6));
    repeat (100) @(negedge clk);
    cur_req = "R10";
    wr('h19, mk(0, 0, 0));
    wr('h1C, mk(0, 0, 7));
    repeat (100) @(negedge clk);

    // R6: upper code bits ignored in basic mode
    cur_req = "R6";
    wr('h19, mk(0, 0, 11));
    wr('h1D, mk(1, 1, 14));
    wr('h1A, mk(0, 1, 24));
    wr('h18, mk(0, 1, 31));
    repeat (500) @(negedge clk);

    // R7: extension bit and full-rate code
    cur_req = "R7";
    wr('h20, 8'h01);
    wr('h18, mk(0, 0, 11));
    repeat (20) @(negedge clk);
    #3;
    check1(cnt_clk_en[0] === 1'b1, "R7 full rate", cnt_clk_en, '1);

    // R8: unassigned extended codes
    cur_req = "R8";
    wr('h18, mk(0, 2, 8));
    wr('h1B, mk(0, 1, 12));
    wr('h1C, mk(1, 0, 31));
    wr('h18, mk(1, 2, 10));
    repeat (20) @(negedge clk);
    #3;
    check1(cnt_clk_en[2] === 1'b0, "R8 clk low", cnt_clk_en, '0);
    check1(cnt_gate[1] === 1'b0, "R8 gate low", cnt_gate, '0);

    // R6 again: clearing the extension bit masks stored codes
    cur_req = "R6";
    wr('h20, 8'h00);
    repeat (40) @(negedge clk);

    // R9: foreign addresses
    cur_req = "R9";
    wr('h1E, 8'hFF);
    wr('h00, 8'h29);
    wr('h21, 8'h01);
    wr('h17, 8'h0B);
    wr('h3F, 8'hFF);
    repeat (40) @(negedge clk);

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule